// File: doc/BRIEF.md
# Cache Line-Delete Error Tracker

This block runs alongside a set-associative cache array. It follows the error status of every array read and keeps a small saturating count of uncorrectable errors for each (row, way) entry. When a count climbs to a software-set threshold, the block raises a service request that names the entry. The request stays up until a service agent acknowledges it.

The agent can then retire the entry with a configuration write. From the next cycle on, the block refuses direct writes to a retired entry. When the write path asks the block to pick a way, it steers that write to the lowest-numbered way of the class that is still in service. A class whose ways are all retired drops the write and flags an error in the same cycle.

ECC generation and checking, the data array and the service agent are outside the block. The per-read error status comes in as an input.

Top module: `line_delete_tracker`

## Requirements
- R1: After reset every counter is zero, no entry is deleted, the threshold is zero and `svc_req_o` is low.
- R2: A read with status 0 (clean), 1 (corrected single-bit) or 3 (reserved) never changes any counter.
- R3: A read with status 2 (uncorrectable) adds one to the counter of exactly the read entry, whose flat index is row*WAYS+way, and leaves every other counter unchanged.
- R4: When an uncorrectable read raises an entry's count to exactly the threshold, that entry becomes pending. The comparison uses the threshold held before that cycle's configuration write. `svc_req_o` is high while any entry is pending, and `svc_row_o`/`svc_way_o` name the pending entry with the lowest flat index.
- R5: A pending entry stays pending until `svc_ack_i` is high in a cycle where that entry is the one presented. That cycle's acknowledge clears only the presented entry.
- R6: A threshold of zero never makes any entry pending.
- R7: A counter stops at 2^CNT_W-1 and never wraps, so further uncorrectable reads on that entry raise no new request.
- R8: Configuration op 1 (delete) marks the entry deleted from the next cycle on. A direct write (`wr_alloc_i`=0) to a deleted entry gives `wr_en_o`=0, while writes to the other ways of the class are still enabled.
- R9: A write with `wr_alloc_i`=1 is enabled on the lowest-numbered non-deleted way of its row, given on `wr_way_o`. `wr_way_o` is 0 whenever `wr_en_o` is low.
- R10: A write with `wr_alloc_i`=1 to a row whose ways are all deleted gives `wr_en_o`=0 and `wr_drop_o`=1 in the same cycle. `wr_drop_o` is 0 in every other case.
- R11: Configuration op 2 (clear) zeroes the chosen counter, and it wins over an uncorrectable read of the same entry in the same cycle. Op 0 loads the threshold from `cfg_data_i`. Op 3 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | Array read this cycle |
| rd_row_i | input | ROW_W | Row of the read |
| rd_way_i | input | WAY_W | Way of the read |
| rd_status_i | input | 2 | 0 clean, 1 corrected, 2 uncorrectable, 3 reserved |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 2 | 0 threshold, 1 delete, 2 clear counter, 3 none |
| cfg_row_i | input | ROW_W | Row for delete/clear |
| cfg_way_i | input | WAY_W | Way for delete/clear |
| cfg_data_i | input | CNT_W | Threshold value |
| wr_valid_i | input | 1 | Array write request |
| wr_alloc_i | input | 1 | 1: block picks the way, 0: use wr_way_i |
| wr_row_i | input | ROW_W | Row of the write |
| wr_way_i | input | WAY_W | Way for a direct write |
| wr_en_o | output | 1 | Write may proceed |
| wr_way_o | output | WAY_W | Way to write, 0 when not enabled |
| wr_drop_o | output | 1 | Allocating write dropped, row fully deleted |
| svc_req_o | output | 1 | Service request pending |
| svc_row_o | output | ROW_W | Row of the presented entry |
| svc_way_o | output | WAY_W | Way of the presented entry |
| svc_ack_i | input | 1 | Acknowledge of the presented entry |

## Verification
A wrong counter is hidden until the request timing exposes it. An error counted too many or too few times moves the cycle in which `svc_req_o` rises for that entry. A wrap after saturation brings back a request that should never reappear. Such faults therefore show only when the bench pushes an entry to the threshold or past the maximum.

A wrong pending bit shows as soon as it becomes the lowest pending entry. A corrupted deleted bit shows on the very next write to that row, in the same cycle, through `wr_en_o`, `wr_way_o` or `wr_drop_o`.

// File: rtl/lde_pkg.sv
package lde_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_CORR   = 2'd1,
    ST_UNCORR = 2'd2,
    ST_RSVD   = 2'd3
  } rd_status_e;

  typedef enum logic [1:0] {
    OP_THRESH = 2'd0,
    OP_DELETE = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_NONE   = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/lde_err_counters.sv
module lde_err_counters #(
  parameter int ENTRIES = 32,
  parameter int CNT_W   = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_valid_i,
  input  logic               rd_uncorr_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  input  logic               thr_we_i,
  input  logic [CNT_W-1:0]   thr_i,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  output logic [ENTRIES-1:0] flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]   thr_q;
  logic [ENTRIES-1:0] flag_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_q <= '0;
    else if (thr_we_i) thr_q <= thr_i;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_q;
    logic             inc, clr, reach;

    assign inc   = rd_valid_i && rd_uncorr_i && (rd_idx_i == IDX_W'(e));
    assign clr   = clr_i && (clr_idx_i == IDX_W'(e));
    // old threshold is used when it is rewritten in the same cycle
    assign reach = inc && !clr && (cnt_q != CNT_MAX) && (thr_q != '0) &&
                   (CNT_W'(cnt_q + 1'b1) == thr_q);

    always_comb begin
      cnt_d = cnt_q;
      if (clr)                          cnt_d = '0;
      else if (inc && cnt_q != CNT_MAX) cnt_d = CNT_W'(cnt_q + 1'b1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        if (reach)                                 flag_q <= 1'b1;
        else if (ack_i && ack_idx_i == IDX_W'(e))  flag_q <= 1'b0;
      end
    end

    assign flag_w[e] = flag_q;

    // R7: a saturated counter holds unless cleared
    p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);
    // R2: reads that are not uncorrectable leave the counter alone
    p_soft_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_i && !rd_uncorr_i && !clr) |=> $stable(cnt_q));
  end

  assign flag_o = flag_w;

  // R6: zero threshold never creates a pending entry
  p_thr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q == '0 && flag_w == '0) |=> flag_w == '0);
endmodule

// File: rtl/lde_delete_map.sv
module lde_delete_map #(
  parameter int ROWS   = 8,
  parameter int WAYS   = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             del_we_i,
  input  logic [ROW_W-1:0] del_row_i,
  input  logic [WAY_W-1:0] del_way_i,
  input  logic             wr_valid_i,
  input  logic             wr_alloc_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [WAY_W-1:0] wr_way_i,
  output logic             wr_en_o,
  output logic [WAY_W-1:0] wr_way_o,
  output logic             wr_drop_o
);
  logic [WAYS-1:0] del_q [ROWS];
  logic [WAYS-1:0] row_del;
  logic            free_found;
  logic [WAY_W-1:0] free_way;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) del_q[r] <= '0;
      else if (del_we_i && del_row_i == ROW_W'(r))
        del_q[r] <= del_q[r] | (WAYS'(1) << del_way_i);
    end

    // R8: a deleted entry stays deleted
    p_del_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((del_q[r] & $past(del_q[r])) == $past(del_q[r])));
  end

  assign row_del = del_q[wr_row_i];

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_del[w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_way_o  = '0;
    wr_drop_o = 1'b0;
    if (wr_valid_i) begin
      if (wr_alloc_i) begin
        wr_en_o   = free_found;
        wr_way_o  = free_found ? free_way : '0;
        wr_drop_o = !free_found;
      end else if (!row_del[wr_way_i]) begin
        wr_en_o  = 1'b1;
        wr_way_o = wr_way_i;
      end
    end
  end

  // R10: a dropped write is never enabled
  always_comb begin
    p_drop_excl_r10: assert (!(wr_en_o && wr_drop_o));
  end
endmodule

// File: rtl/lde_svc_arb.sv
module lde_svc_arb #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] flag_i,
  output logic               req_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    req_o = 1'b0;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (flag_i[i]) begin
        req_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/line_delete_tracker.sv
module line_delete_tracker #(
  parameter int ROWS   = 8,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 3,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_valid_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [WAY_W-1:0] rd_way_i,
  input  logic [1:0]       rd_status_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_op_i,
  input  logic [ROW_W-1:0] cfg_row_i,
  input  logic [WAY_W-1:0] cfg_way_i,
  input  logic [CNT_W-1:0] cfg_data_i,
  input  logic             wr_valid_i,
  input  logic             wr_alloc_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [WAY_W-1:0] wr_way_i,
  output logic             wr_en_o,
  output logic [WAY_W-1:0] wr_way_o,
  output logic             wr_drop_o,
  output logic             svc_req_o,
  output logic [ROW_W-1:0] svc_row_o,
  output logic [WAY_W-1:0] svc_way_o,
  input  logic             svc_ack_i
);
  import lde_pkg::*;

  localparam int ENTRIES = ROWS * WAYS;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  rd_status_e       rd_status;
  cfg_op_e          cfg_op;
  logic [IDX_W-1:0] rd_idx, cfg_idx, svc_idx;
  logic [ENTRIES-1:0] flags;
  logic             rd_uncorr;

  assign rd_status = rd_status_e'(rd_status_i);
  assign cfg_op    = cfg_op_e'(cfg_op_i);
  assign rd_uncorr = (rd_status == ST_UNCORR);
  assign rd_idx    = IDX_W'(IDX_W'(rd_row_i) * IDX_W'(WAYS) + IDX_W'(rd_way_i));
  assign cfg_idx   = IDX_W'(IDX_W'(cfg_row_i) * IDX_W'(WAYS) + IDX_W'(cfg_way_i));

  lde_err_counters #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_valid_i  (rd_valid_i),
    .rd_uncorr_i (rd_uncorr),
    .rd_idx_i    (rd_idx),
    .clr_i       (cfg_we_i && cfg_op == OP_CLEAR),
    .clr_idx_i   (cfg_idx),
    .thr_we_i    (cfg_we_i && cfg_op == OP_THRESH),
    .thr_i       (cfg_data_i),
    .ack_i       (svc_ack_i && svc_req_o),
    .ack_idx_i   (svc_idx),
    .flag_o      (flags)
  );

  lde_svc_arb #(.ENTRIES(ENTRIES)) u_arb (
    .flag_i (flags),
    .req_o  (svc_req_o),
    .idx_o  (svc_idx)
  );

  assign svc_row_o = ROW_W'(svc_idx / IDX_W'(WAYS));
  assign svc_way_o = WAY_W'(svc_idx % IDX_W'(WAYS));

  lde_delete_map #(.ROWS(ROWS), .WAYS(WAYS)) u_del (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .del_we_i   (cfg_we_i && cfg_op == OP_DELETE),
    .del_row_i  (cfg_row_i),
    .del_way_i  (cfg_way_i),
    .wr_valid_i (wr_valid_i),
    .wr_alloc_i (wr_alloc_i),
    .wr_row_i   (wr_row_i),
    .wr_way_i   (wr_way_i),
    .wr_en_o    (wr_en_o),
    .wr_way_o   (wr_way_o),
    .wr_drop_o  (wr_drop_o)
  );

  // R5: request holds until acknowledged
  p_req_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_req_o && !svc_ack_i) |=> svc_req_o);
  // R5: acknowledging the only pending entry, with no new error, drops the request
  p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_req_o && svc_ack_i && $countones(flags) == 1 && !(rd_valid_i && rd_uncorr))
    |=> !svc_req_o);
endmodule

// File: tb/line_delete_tracker_bench.sv
module line_delete_tracker_bench;
  localparam int ROWS = 8, WAYS = 4, CNT_W = 3;
  localparam int NENT = ROWS * WAYS;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_valid, cfg_we, wr_valid, wr_alloc, svc_ack;
  logic [2:0] rd_row, cfg_row, wr_row;
  logic [1:0] rd_way, cfg_way, wr_way, rd_status, cfg_op;
  logic [CNT_W-1:0] cfg_data;
  logic wr_en, wr_drop, svc_req;
  logic [1:0] wr_way_q, svc_way;
  logic [2:0] svc_row;

  line_delete_tracker #(.ROWS(ROWS), .WAYS(WAYS), .CNT_W(CNT_W)) u_line_delete_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_valid_i(rd_valid), .rd_row_i(rd_row), .rd_way_i(rd_way), .rd_status_i(rd_status),
    .cfg_we_i(cfg_we), .cfg_op_i(cfg_op), .cfg_row_i(cfg_row), .cfg_way_i(cfg_way),
    .cfg_data_i(cfg_data),
    .wr_valid_i(wr_valid), .wr_alloc_i(wr_alloc), .wr_row_i(wr_row), .wr_way_i(wr_way),
    .wr_en_o(wr_en), .wr_way_o(wr_way_q), .wr_drop_o(wr_drop),
    .svc_req_o(svc_req), .svc_row_o(svc_row), .svc_way_o(svc_way), .svc_ack_i(svc_ack)
  );

  always #10 clk = ~clk;

  int n_checks = 0, n_fail = 0, cycles = 0;
  string tag = "R1";

  int  m_cnt [NENT];
  bit  m_flag [NENT];
  bit  m_del [ROWS][WAYS];
  int  m_thr;

  task automatic chk(bit ok, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NENT; i++) begin m_cnt[i] = 0; m_flag[i] = 0; end
    for (int r = 0; r < ROWS; r++) for (int w = 0; w < WAYS; w++) m_del[r][w] = 0;
    m_thr = 0;
  endtask

  task automatic idle();
    rd_valid = 0; rd_row = 0; rd_way = 0; rd_status = 0;
    cfg_we = 0; cfg_op = 3; cfg_row = 0; cfg_way = 0; cfg_data = 0;
    wr_valid = 0; wr_alloc = 0; wr_row = 0; wr_way = 0; svc_ack = 0;
  endtask

  // inputs already driven just after a negedge
  task automatic tick();
    int sel, f, e_way, reach, idx;
    bit e_en, e_drop;
    #2;
    sel = -1;
    for (int i = NENT - 1; i >= 0; i--) if (m_flag[i]) sel = i;
    chk(svc_req == (sel >= 0), "svc_req", svc_req, sel >= 0);
    if (sel >= 0) begin
      chk(svc_row == sel / WAYS, "svc_row", svc_row, sel / WAYS);
      chk(svc_way == sel % WAYS, "svc_way", svc_way, sel % WAYS);
    end
    e_en = 0; e_way = 0; e_drop = 0;
    if (wr_valid) begin
      if (wr_alloc) begin
        f = -1;
        for (int w = WAYS - 1; w >= 0; w--) if (!m_del[wr_row][w]) f = w;
        e_en = (f >= 0); e_way = (f >= 0) ? f : 0; e_drop = (f < 0);
      end else begin
        e_en = !m_del[wr_row][wr_way]; e_way = e_en ? int'(wr_way) : 0;
      end
      chk(wr_en == e_en, "wr_en", wr_en, e_en);
      chk(wr_way_q == e_way, "wr_way", wr_way_q, e_way);
      chk(wr_drop == e_drop, "wr_drop", wr_drop, e_drop);
    end else begin
      chk(!wr_en && !wr_drop && wr_way_q == 0, "wr_idle", {wr_en, wr_drop}, 0);
    end
    // state update for the coming edge
    reach = -1;
    if (rd_valid && rd_status == 2) begin
      idx = rd_row * WAYS + rd_way;
      if (!(cfg_we && cfg_op == 2 && cfg_row * WAYS + cfg_way == idx) && m_cnt[idx] < CMAX) begin
        if (m_thr != 0 && m_cnt[idx] + 1 == m_thr) reach = idx;
        m_cnt[idx]++;
      end
    end
    if (svc_ack && sel >= 0 && sel != reach) m_flag[sel] = 0;
    if (reach >= 0) m_flag[reach] = 1;
    if (cfg_we) begin
      case (cfg_op)
        2'd0: m_thr = cfg_data;
        2'd1: m_del[cfg_row][cfg_way] = 1;
        2'd2: m_cnt[cfg_row * WAYS + cfg_way] = 0;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic ue(int row, int way, int n);
    for (int k = 0; k < n; k++) begin
      idle(); rd_valid = 1; rd_row = 3'(row); rd_way = 2'(way); rd_status = 2; tick();
    end
  endtask

  task automatic cfg(int op, int row, int way, int data);
    idle(); cfg_we = 1; cfg_op = 2'(op); cfg_row = 3'(row); cfg_way = 2'(way);
    cfg_data = CNT_W'(data); tick();
  endtask

  task automatic ack();
    idle(); svc_ack = 1; tick();
  endtask

  task automatic wr(bit alloc, int row, int way);
    idle(); wr_valid = 1; wr_alloc = alloc; wr_row = 3'(row); wr_way = 2'(way); tick();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; idle(); model_reset();
    #2;
    chk(!svc_req, "reset svc_req", svc_req, 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    idle(); model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    for (int r = 0; r < ROWS; r++) for (int w = 0; w < WAYS; w++) wr(0, r, w);
    wr(1, 5, 0);
    tag = "R6"; ue(1, 2, 10);
    tag = "R11"; cfg(2, 1, 2, 0);
    tag = "R2"; cfg(0, 0, 0, 2);
    for (int k = 0; k < 6; k++) begin
      idle(); rd_valid = 1; rd_row = 3; rd_way = 1; rd_status = 2'(k % 2 == 0 ? 1 : (k == 3 ? 3 : 0)); tick();
    end
    tag = "R4"; ue(3, 1, 1); ue(3, 1, 1);
    tag = "R5"; repeat (3) begin idle(); tick(); end
    ack(); idle(); tick();
    tag = "R3"; cfg(0, 0, 0, 3);
    ue(0, 0, 2); ue(5, 3, 2); ue(0, 0, 1); ue(5, 3, 1);
    tag = "R5"; idle(); tick(); ack(); ack(); idle(); tick();
    tag = "R11";
    cfg(2, 5, 3, 0); ue(5, 3, 3); ack();
    idle(); cfg_we = 1; cfg_op = 2; cfg_row = 5; cfg_way = 3;
    rd_valid = 1; rd_row = 5; rd_way = 3; rd_status = 2; tick();
    ue(5, 3, 3); ack();
    // threshold rewrite while reaching old value: old threshold governs
    tag = "R4"; ue(6, 0, 2);
    idle(); cfg_we = 1; cfg_op = 0; cfg_data = 5; rd_valid = 1; rd_row = 6; rd_way = 0; rd_status = 2; tick();
    ack(); idle(); tick();
    tag = "R7"; cfg(0, 0, 0, 7);
    for (int k = 0; k < 16; k++) begin
      ue(7, 0, 1);
      if (svc_req) ack();
    end
    tag = "R8";
    cfg(1, 2, 1, 0);
    wr(0, 2, 1); wr(0, 2, 0); wr(0, 2, 2); wr(0, 6, 1);
    idle(); cfg_we = 1; cfg_op = 1; cfg_row = 2; cfg_way = 3; wr_valid = 1; wr_row = 2; wr_way = 3; tick();
    wr(0, 2, 3);
    tag = "R9"; wr(1, 2, 0); cfg(1, 2, 0, 0); wr(1, 2, 0); wr(1, 4, 3);
    tag = "R10"; cfg(1, 2, 2, 0); wr(1, 2, 1); wr(0, 2, 2);
    tag = "R1"; do_reset();
    wr(1, 2, 0); cfg(0, 0, 0, 1); ue(7, 0, 1); idle(); tick();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule